// File: doc/BRIEF.md
# Channel Bank Debug Access Controller

This block decides who drives a bank of measurement channels: the online calibration engine or an external debug host. The host raises a freeze request and keeps it high. The block passes the request to the engine as a halt. Once the engine reports that it has reached an idle point between calibration cycles, the block hands the bank to the debug port and raises an acknowledge. Dropping the request returns the bank to the engine.

While the host holds the bank, a cursor selects one channel at a time. A next pulse steps the cursor, and the cursor wraps from the last channel back to the first. Through the selected channel the host can do the following:
- read the channel's lookup table and histogram, each with one cycle of latency;
- switch the channel's input to the calibration source;
- start a ring oscillator frequency measurement;
- read the measured frequency and the frequency stored at startup.

Every channel's per-channel buses are multiplexed onto the single debug port. All signals are synchronous to one clock and active high.

Top module: `chbank_dbg_ctrl`

## Requirements
- R1: `hold_ack_o` rises one cycle after a clock edge at which `hold_req_i` and `eng_idle_i` are both high. It stays low while the engine has not reported idle.
- R2: While `hold_req_i` is high and `hold_ack_o` is still low, debug commands have no effect. This covers cursor steps, calibration select and measurement starts.
- R3: `eng_halt_o` follows `hold_req_i`. When `hold_req_i` is low, `hold_ack_o` is low from the next cycle on.
- R4: While `hold_ack_o` is low, the other debug inputs have no effect. `ch_calsel_o` and `ch_oc_start_o` stay zero, the cursor does not move, and `dbg_lut_q_o` and `dbg_his_q_o` hold their values.
- R5: A `sel_next_i` pulse while acknowledged moves the cursor from channel k to channel k+1. From channel N_CH-1 it moves to channel 0.
- R6: `sel_last_o` is high exactly when the cursor is on channel N_CH-1.
- R7: While acknowledged, `dbg_cal_i` drives `ch_calsel_o` bit k high only for the cursor channel k. All other bits stay zero.
- R8: `dbg_lut_addr_i` is forwarded to every channel while acknowledged. One clock edge later, `dbg_lut_q_o` shows the cursor channel's `ch_lut_data_i` slice, which is bits k*LUT_DW and up.
- R9: The histogram pair `dbg_his_addr_i` and `dbg_his_q_o` behaves the same way, with the same one-cycle latency.
- R10: A `dbg_oc_go_i` pulse while acknowledged and ready drives `ch_oc_start_o` bit k high for the cursor channel k only. A pulse while that channel is busy is dropped.
- R11: `dbg_oc_rdy_o` is the inverse of the cursor channel's `ch_oc_busy_i` bit. `dbg_freq_o` shows that channel's `ch_freq_i` slice while ready and 0 otherwise.
- R12: `dbg_sfreq_o` always shows the cursor channel's `ch_sfreq_i` slice.
- R13: The cursor is channel 0 after reset and at every new rise of `hold_ack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hold_req_i | input | 1 | Freeze request, held high by the debug host |
| hold_ack_o | output | 1 | Bank handed to the debug port |
| eng_idle_i | input | 1 | Calibration engine is at an idle point |
| eng_halt_o | output | 1 | Asks the engine to stop at its next idle point |
| sel_next_i | input | 1 | Step the cursor to the next channel |
| sel_last_o | output | 1 | Cursor is on the last channel |
| dbg_cal_i | input | 1 | Switch the cursor channel's input to the calibration source |
| dbg_lut_addr_i | input | LUT_AW | Lookup table read address |
| dbg_lut_q_o | output | LUT_DW | Lookup table read data |
| dbg_his_addr_i | input | HIS_AW | Histogram read address |
| dbg_his_q_o | output | HIS_DW | Histogram read data |
| dbg_oc_go_i | input | 1 | Start a frequency measurement |
| dbg_oc_rdy_o | output | 1 | No measurement running on the cursor channel |
| dbg_freq_o | output | FREQ_W | Measured frequency, valid while ready |
| dbg_sfreq_o | output | FREQ_W | Startup frequency of the cursor channel |
| ch_calsel_o | output | N_CH | Per-channel calibration input select |
| ch_lut_addr_o | output | LUT_AW | Lookup table address sent to all channels |
| ch_lut_data_i | input | N_CH*LUT_DW | Per-channel lookup table data |
| ch_his_addr_o | output | HIS_AW | Histogram address sent to all channels |
| ch_his_data_i | input | N_CH*HIS_DW | Per-channel histogram data |
| ch_oc_start_o | output | N_CH | Per-channel measurement start |
| ch_oc_busy_i | input | N_CH | Per-channel measurement in progress |
| ch_freq_i | input | N_CH*FREQ_W | Per-channel measured frequency |
| ch_sfreq_i | input | N_CH*FREQ_W | Per-channel startup frequency |

## Verification
The bench builds the block with N_CH=3. Because 3 is not a power of two, the wrap from channel 2 to channel 0 must come from the compare against the last index and cannot come from counter overflow. Three steps are enough to go around the whole bank. The bench uses LUT_AW=HIS_AW=4 and LUT_DW=HIS_DW=8, so each stub's read data encodes both the channel and the address. This shows in a single read whether the data came from the right channel and the right address. With FREQ_W=12, each channel has its own base frequency. A measurement whose start was dropped therefore shows up as a count that is off by one, and a start sent to the wrong channel changes another channel's value.

// File: rtl/chbank_dbg_ctrl.sv
module chbank_dbg_ctrl #(
  parameter int N_CH   = 4,
  parameter int LUT_AW = 4,
  parameter int LUT_DW = 8,
  parameter int HIS_AW = 4,
  parameter int HIS_DW = 8,
  parameter int FREQ_W = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     hold_req_i,
  output logic                     hold_ack_o,
  input  logic                     eng_idle_i,
  output logic                     eng_halt_o,
  input  logic                     sel_next_i,
  output logic                     sel_last_o,
  input  logic                     dbg_cal_i,
  input  logic [LUT_AW-1:0]        dbg_lut_addr_i,
  output logic [LUT_DW-1:0]        dbg_lut_q_o,
  input  logic [HIS_AW-1:0]        dbg_his_addr_i,
  output logic [HIS_DW-1:0]        dbg_his_q_o,
  input  logic                     dbg_oc_go_i,
  output logic                     dbg_oc_rdy_o,
  output logic [FREQ_W-1:0]        dbg_freq_o,
  output logic [FREQ_W-1:0]        dbg_sfreq_o,
  output logic [N_CH-1:0]          ch_calsel_o,
  output logic [LUT_AW-1:0]        ch_lut_addr_o,
  input  logic [N_CH*LUT_DW-1:0]   ch_lut_data_i,
  output logic [HIS_AW-1:0]        ch_his_addr_o,
  input  logic [N_CH*HIS_DW-1:0]   ch_his_data_i,
  output logic [N_CH-1:0]          ch_oc_start_o,
  input  logic [N_CH-1:0]          ch_oc_busy_i,
  input  logic [N_CH*FREQ_W-1:0]   ch_freq_i,
  input  logic [N_CH*FREQ_W-1:0]   ch_sfreq_i
);
  localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam logic [CW-1:0] LAST = CW'(N_CH - 1);

  logic          ack_q;
  logic [CW-1:0] cur_q;
  logic [N_CH-1:0] cur_oh;

  assign hold_ack_o = ack_q;
  assign eng_halt_o = hold_req_i;
  assign sel_last_o = (cur_q == LAST);
  assign cur_oh     = N_CH'(1) << cur_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !hold_req_i) ack_q <= 1'b0;
    else if (eng_idle_i)      ack_q <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !ack_q)  cur_q <= '0;
    else if (sel_next_i)  cur_q <= sel_last_o ? '0 : cur_q + CW'(1);
  end

  assign ch_lut_addr_o = ack_q ? dbg_lut_addr_i : '0;
  assign ch_his_addr_o = ack_q ? dbg_his_addr_i : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dbg_lut_q_o <= '0;
      dbg_his_q_o <= '0;
    end else if (ack_q) begin
      dbg_lut_q_o <= ch_lut_data_i[cur_q*LUT_DW +: LUT_DW];
      dbg_his_q_o <= ch_his_data_i[cur_q*HIS_DW +: HIS_DW];
    end
  end

  assign ch_calsel_o   = (ack_q && dbg_cal_i) ? cur_oh : '0;
  assign dbg_oc_rdy_o  = !ch_oc_busy_i[cur_q];
  assign ch_oc_start_o = (ack_q && dbg_oc_go_i && dbg_oc_rdy_o) ? cur_oh : '0;
  assign dbg_freq_o    = dbg_oc_rdy_o ? ch_freq_i[cur_q*FREQ_W +: FREQ_W] : '0;
  assign dbg_sfreq_o   = ch_sfreq_i[cur_q*FREQ_W +: FREQ_W];
endmodule

// File: rtl/chbank_dbg_chk.sv
module chbank_dbg_chk #(
  parameter int N_CH = 4,
  parameter int LUT_DW = 8,
  parameter int HIS_DW = 8,
  parameter int CW = 2
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              hold_req_i,
  input logic              eng_idle_i,
  input logic              hold_ack_o,
  input logic              sel_next_i,
  input logic              sel_last_o,
  input logic [CW-1:0]     cur_q,
  input logic [N_CH-1:0]   ch_calsel_o,
  input logic [N_CH-1:0]   ch_oc_start_o,
  input logic [LUT_DW-1:0] dbg_lut_q_o,
  input logic [HIS_DW-1:0] dbg_his_q_o
);
  // R1
  ack_needs_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(hold_ack_o) |-> $past(hold_req_i && eng_idle_i));
  // R3
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !hold_req_i |=> !hold_ack_o);
  // R5
  cursor_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hold_ack_o && hold_req_i && sel_next_i && sel_last_o |=> cur_q == '0);
  // R13
  grant_home_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(hold_ack_o) |-> cur_q == '0);
  // R7
  calsel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(ch_calsel_o) && (hold_ack_o || ch_calsel_o == '0));
  // R10
  start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(ch_oc_start_o) && (hold_ack_o || ch_oc_start_o == '0));
  // R4
  read_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !hold_ack_o |=> $stable(dbg_lut_q_o) && $stable(dbg_his_q_o));
endmodule

bind chbank_dbg_ctrl chbank_dbg_chk #(
  .N_CH(N_CH), .LUT_DW(LUT_DW), .HIS_DW(HIS_DW), .CW(CW)
) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .hold_req_i(hold_req_i), .eng_idle_i(eng_idle_i),
  .hold_ack_o(hold_ack_o), .sel_next_i(sel_next_i), .sel_last_o(sel_last_o),
  .cur_q(cur_q), .ch_calsel_o(ch_calsel_o), .ch_oc_start_o(ch_oc_start_o),
  .dbg_lut_q_o(dbg_lut_q_o), .dbg_his_q_o(dbg_his_q_o)
);

// File: tb/chbank_dbg_ctrl_tb_top.sv
`timescale 1ns/1ps
module chbank_dbg_ctrl_tb_top;
  localparam int N = 3, AW = 4, DW = 8, FW = 12;

  logic clk_i = 0, rst_i = 1;
  logic hold_req_i = 0, eng_idle_i = 0, sel_next_i = 0, dbg_cal_i = 0, dbg_oc_go_i = 0;
  logic [AW-1:0] dbg_lut_addr_i = 0, dbg_his_addr_i = 0;
  logic hold_ack_o, eng_halt_o, sel_last_o, dbg_oc_rdy_o;
  logic [DW-1:0] dbg_lut_q_o, dbg_his_q_o;
  logic [FW-1:0] dbg_freq_o, dbg_sfreq_o;
  logic [N-1:0] ch_calsel_o, ch_oc_start_o, ch_oc_busy_i;
  logic [AW-1:0] ch_lut_addr_o, ch_his_addr_o;
  logic [N*DW-1:0] ch_lut_data_i, ch_his_data_i;
  logic [N*FW-1:0] ch_freq_i, ch_sfreq_i;

  int total = 0, bad = 0;

  always #4 clk_i = ~clk_i;

  chbank_dbg_ctrl #(.N_CH(N), .LUT_AW(AW), .LUT_DW(DW), .HIS_AW(AW), .HIS_DW(DW), .FREQ_W(FW)) dut_i (.*);

  for (genvar c = 0; c < N; c++) begin : g_stub
    logic [3:0] cnt;
    logic [FW-1:0] freq;
    assign ch_lut_data_i[c*DW +: DW] = DW'(c*16) + DW'(ch_lut_addr_o);
    assign ch_his_data_i[c*DW +: DW] = (DW'(c*16) + DW'(ch_his_addr_o)) ^ 8'h5A;
    assign ch_freq_i[c*FW +: FW]     = freq;
    assign ch_sfreq_i[c*FW +: FW]    = FW'(50 + c);
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        ch_oc_busy_i[c] <= 1'b0; cnt <= '0; freq <= FW'(100 * (c + 1));
      end else if (ch_oc_start_o[c] && !ch_oc_busy_i[c]) begin
        ch_oc_busy_i[c] <= 1'b1; cnt <= 4'(3 + c);
      end else if (ch_oc_busy_i[c]) begin
        cnt <= cnt - 4'd1;
        if (cnt == 4'd1) begin ch_oc_busy_i[c] <= 1'b0; freq <= freq + FW'(1); end
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk_i); #1; end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    sel_next_i = 1; tick(); sel_next_i = 0;
  endtask

  task automatic t_reset();
    chk("R3 ack after reset", 32'(hold_ack_o), 0);
    chk("R6 last after reset", 32'(sel_last_o), 0);
    chk("R13 cursor ch0 after reset", 32'(dbg_sfreq_o), 50);
    chk("R11 ready after reset", 32'(dbg_oc_rdy_o), 1);
    chk("R7 calsel after reset", 32'(ch_calsel_o), 0);
  endtask

  task automatic t_grant();
    hold_req_i = 1; eng_idle_i = 0;
    #1 chk("R3 halt follows req", 32'(eng_halt_o), 1);
    sel_next_i = 1; dbg_cal_i = 1; dbg_oc_go_i = 1;
    #1 chk("R2 no calsel before ack", 32'(ch_calsel_o), 0);
    chk("R2 no start before ack", 32'(ch_oc_start_o), 0);
    tick(3);
    chk("R1 no ack without idle", 32'(hold_ack_o), 0);
    sel_next_i = 0; dbg_cal_i = 0; dbg_oc_go_i = 0;
    chk("R2 cursor unmoved", 32'(dbg_sfreq_o), 50);
    eng_idle_i = 1; tick();
    chk("R1 ack after idle", 32'(hold_ack_o), 1);
    eng_idle_i = 0;
  endtask

  task automatic t_cursor();
    step(); chk("R5 step to ch1", 32'(dbg_sfreq_o), 51);
    chk("R6 not last at ch1", 32'(sel_last_o), 0);
    step(); chk("R6 last at ch2", 32'(sel_last_o), 1);
    chk("R12 sfreq ch2", 32'(dbg_sfreq_o), 52);
    step(); chk("R5 wrap to ch0", 32'(dbg_sfreq_o), 50);
    chk("R6 not last after wrap", 32'(sel_last_o), 0);
  endtask

  task automatic t_reads();
    step();
    dbg_lut_addr_i = 4'd7; dbg_his_addr_i = 4'd3;
    #1 chk("R8 lut latency old value", 32'(dbg_lut_q_o === 8'h17), 0);
    tick();
    chk("R8 lut ch1 a7", 32'(dbg_lut_q_o), 32'h17);
    chk("R9 his ch1 a3", 32'(dbg_his_q_o), 32'h13 ^ 32'h5A);
    dbg_lut_addr_i = 4'd12; tick();
    chk("R8 lut ch1 a12", 32'(dbg_lut_q_o), 32'h1C);
  endtask

  task automatic t_calsel();
    dbg_cal_i = 1;
    #1 chk("R7 calsel ch1", 32'(ch_calsel_o), 32'b010);
    step(); chk("R7 calsel ch2", 32'(ch_calsel_o), 32'b100);
    dbg_cal_i = 0;
    #1 chk("R7 calsel off", 32'(ch_calsel_o), 0);
    step(); step();
  endtask

  task automatic t_measure();
    dbg_oc_go_i = 1;
    #1 chk("R10 start ch1 only", 32'(ch_oc_start_o), 32'b010);
    tick(); dbg_oc_go_i = 1;
    chk("R11 busy not ready", 32'(dbg_oc_rdy_o), 0);
    chk("R11 freq zero while busy", 32'(dbg_freq_o), 0);
    #1 chk("R10 go dropped while busy", 32'(ch_oc_start_o), 0);
    tick(); dbg_oc_go_i = 0;
    tick(8);
    chk("R11 ready again", 32'(dbg_oc_rdy_o), 1);
    chk("R10 one measurement only", 32'(dbg_freq_o), 201);
    step();
    chk("R10 other channel untouched", 32'(dbg_freq_o), 300);
  endtask

  task automatic t_release();
    logic [DW-1:0] lq;
    hold_req_i = 0; tick();
    chk("R3 ack drops", 32'(hold_ack_o), 0);
    chk("R3 halt drops", 32'(eng_halt_o), 0);
    lq = dbg_lut_q_o;
    sel_next_i = 1; dbg_cal_i = 1; dbg_oc_go_i = 1; dbg_lut_addr_i = 4'd1;
    #1 chk("R4 no calsel released", 32'(ch_calsel_o), 0);
    chk("R4 no start released", 32'(ch_oc_start_o), 0);
    tick(3);
    sel_next_i = 0; dbg_cal_i = 0; dbg_oc_go_i = 0;
    chk("R4 lut data held", 32'(dbg_lut_q_o), 32'(lq));
    chk("R4 cursor not stepped", 32'(dbg_sfreq_o), 50);
    tick(8);
    chk("R4 no measurement", 32'(dbg_freq_o), 100);
    hold_req_i = 1; eng_idle_i = 1; tick();
    chk("R1 regrant", 32'(hold_ack_o), 1);
    chk("R13 cursor home on grant", 32'(dbg_sfreq_o), 50);
    tick();
    chk("R8 read ch0 after regrant", 32'(dbg_lut_q_o), 32'h01);
  endtask

  initial begin
    tick(3); rst_i = 0; tick();
    t_reset();
    t_grant();
    t_cursor();
    t_reads();
    t_calsel();
    t_measure();
    t_release();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule